// File: doc/BRIEF.md
# Interrupt Status Unit with Read-to-Clear Sources

This block collects twelve interrupt sources from an I2C-style bus controller into one sticky raw status register, applies a software mask, and drives a single registered interrupt line. Ten of the sources are event pulses. They set their status bit, and the bit stays set until software clears it. The receive-full and transmit-empty sources are levels that come from FIFO threshold compares. Their bits follow the input and cannot be cleared by software.

Software clears a source by reading. Each source has its own clear address, and one more address clears every clearable source at once. When a transmit abort is flagged, the block also records why the abort happened in a 13-bit reason word. That word is emptied whenever the abort bit is cleared.

Access is through a simple register bus that has a select, a write flag, an address and write data. Read data is registered and appears in the cycle after the read strobe.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the raw status and the abort reason read as 0, the mask reads 0x254 (rx_full, tx_empty, tx_abrt and stop_det enabled), and irqOut is 0.
- R2: Status bit k is set at the clock edge where srcEvent[k] is 1, and it stays set until cleared. The bits are: 0 rx_under, 1 rx_over, 2 rx_full, 3 tx_over, 4 tx_empty, 5 rd_req, 6 tx_abrt, 7 rx_done, 8 activity, 9 stop_det, 10 start_det, 11 gen_call. The raw status reads at address 0x08.
- R3: Bits 2 (rx_full) and 4 (tx_empty) equal their srcEvent input one edge later. No clear read changes them.
- R4: Address 0x04 reads and writes the mask in bits 11:0, and higher write bits are dropped. Address 0x00 reads raw status AND mask.
- R5: A read of address 0x20 + 4*k clears only status bit k, and returns that bit's pre-clear value in rdata bit 0.
- R6: A read of address 0x10 clears every status bit except bits 2 and 4, and returns the pre-clear raw status.
- R7: An event in the same cycle as a clear read of its bit wins, so the bit stays set. This also holds for a tx_abrt event and its reason word.
- R8: On a tx_abrt event (srcEvent[6]) the abortReason input is ORed into the reason word, which reads at 0x0C. The reason bits are: 0 7-bit address nack, 1 first 10-bit address byte nack, 2 second 10-bit address byte nack, 3 data nack, 4 general-call nack, 5 general-call read, 7 start byte acked, 9 start byte with restart off, 10 10-bit read with restart off, 11 controller disabled, 12 arbitration lost. A reason input without the event is ignored. The word is zeroed by a read of 0x38 or 0x10.
- R9: irqOut is a register holding the OR of the masked status. It rises or falls one edge after the status changes.
- R10: Read data appears in busRdata after the edge that takes the read. A write to any address other than 0x04 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| srcEvent | input | 12 | Source events (pulses; bits 2 and 4 are levels) |
| abortReason | input | 13 | Abort reason bits, sampled with srcEvent[6] |
| irqOut | output | 1 | Registered interrupt request |

## Verification
Two things can land in the same cycle: a source event and a software clear read of that same source. The bench provokes this by driving the event and the clear read on one edge, once for a plain source and once for tx_abrt together with a new reason. It then reads the status back and expects the bit to be set. For tx_abrt it also expects the reason word to hold only the new reason, so the clear must have removed the old content. The bench also checks that the clear read returned the bit as it was before that edge, which was 0.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;
  localparam int SRC_N   = 12;
  localparam int ABORT_W = 13;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = $clog2(SRC_N);

  // source bit positions (fixed, decoded by software)
  localparam int B_RX_FULL  = 2;
  localparam int B_TX_EMPTY = 4;
  localparam int B_TX_ABRT  = 6;

  localparam logic [SRC_N-1:0] LEVEL_SRC =
    SRC_N'((1 << B_RX_FULL) | (1 << B_TX_EMPTY));

  localparam logic [ADDR_W-1:0] ADDR_MASKED   = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_MASK     = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_RAW      = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_ABORT    = 8'h0C;
  localparam logic [ADDR_W-1:0] ADDR_CLR_ALL  = 8'h10;
  localparam int                ADDR_CLR_BASE = 'h20;
  localparam int                ADDR_STRIDE   = 4;

  typedef enum logic [2:0] {
    RD_NONE, RD_MASKED, RD_MASK, RD_RAW, RD_ABORT, RD_CLR_ALL, RD_CLR_ONE
  } rdKind_e;

  typedef struct packed {
    logic [SRC_N-1:0] clrVec;
    logic             clrAbort;
    logic             maskWr;
    logic             rdEn;
    rdKind_e          rdKind;
    logic [IDX_W-1:0] rdIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/irqstat_ctrl.sv
module irqstat_ctrl
  import irqstat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        strb
);
  logic             rdAcc;
  logic             wrAcc;
  logic [SRC_N-1:0] oneHit;
  logic             anyOneHit;
  logic [IDX_W-1:0] hitIdx;
  logic             allHit;

  assign rdAcc = busSel && !busWr;
  assign wrAcc = busSel && busWr;

  // one decoder per source clear address
  for (genvar k = 0; k < SRC_N; k++) begin : g_clrDec
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(ADDR_CLR_BASE + k * ADDR_STRIDE);
    assign oneHit[k] = (busAddr == CLR_ADDR);
  end

  assign anyOneHit = |oneHit;
  assign allHit    = (busAddr == ADDR_CLR_ALL);

  always_comb begin
    hitIdx = '0;
    for (int k = 0; k < SRC_N; k++) begin
      if (oneHit[k]) hitIdx = IDX_W'(k);
    end
  end

  always_comb begin
    strb        = '0;
    strb.rdEn   = rdAcc;
    strb.maskWr = wrAcc && (busAddr == ADDR_MASK);
    strb.rdIdx  = hitIdx;
    if (rdAcc) begin
      if (allHit)                     strb.rdKind = RD_CLR_ALL;
      else if (anyOneHit)             strb.rdKind = RD_CLR_ONE;
      else if (busAddr == ADDR_MASKED) strb.rdKind = RD_MASKED;
      else if (busAddr == ADDR_MASK)   strb.rdKind = RD_MASK;
      else if (busAddr == ADDR_RAW)    strb.rdKind = RD_RAW;
      else if (busAddr == ADDR_ABORT)  strb.rdKind = RD_ABORT;
      else                            strb.rdKind = RD_NONE;
    end
    if (rdAcc && allHit)    strb.clrVec = ~LEVEL_SRC;
    if (rdAcc && anyOneHit) strb.clrVec = oneHit & ~LEVEL_SRC;
    strb.clrAbort = strb.clrVec[B_TX_ABRT];
  end

  AST_ONE_CLEAR_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdKind == RD_CLR_ONE) |-> $onehot0(strb.clrVec)) else $error("single clear hit several bits"); // R5
  AST_LEVEL_NEVER_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    busSel |-> ((strb.clrVec & LEVEL_SRC) == '0)) else $error("level source clear strobe"); // R3
endmodule

// File: rtl/irqstat_datapath.sv
module irqstat_datapath
  import irqstat_pkg::*;
#(
  parameter logic [SRC_N-1:0] MASK_RESET = 12'h254
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [SRC_N-1:0]   srcEvent,
  input  logic [ABORT_W-1:0] abortReason,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);
  logic [SRC_N-1:0]   rawQ;
  logic [SRC_N-1:0]   rawNext;
  logic [SRC_N-1:0]   maskQ;
  logic [SRC_N-1:0]   maskedView;
  logic [ABORT_W-1:0] abortQ;
  logic [ABORT_W-1:0] abortNext;
  logic [DATA_W-1:0]  rdNext;
  logic               unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:SRC_N];

  // sticky bits: clear first, then the event ORs back in (event wins);
  // level bits copy their input each edge
  always_comb begin
    rawNext = ((rawQ & ~strb.clrVec) | srcEvent) & ~LEVEL_SRC;
    rawNext = rawNext | (srcEvent & LEVEL_SRC);
  end

  always_comb begin
    abortNext = strb.clrAbort ? '0 : abortQ;
    if (srcEvent[B_TX_ABRT]) abortNext = abortNext | abortReason;
  end

  assign maskedView = rawQ & maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ   <= '0;
      abortQ <= '0;
      maskQ  <= MASK_RESET;
      irqOut <= 1'b0;
    end else begin
      rawQ   <= rawNext;
      abortQ <= abortNext;
      if (strb.maskWr) maskQ <= busWdata[SRC_N-1:0];
      irqOut <= |maskedView;
    end
  end

  always_comb begin
    unique case (strb.rdKind)
      RD_MASKED:  rdNext = DATA_W'(maskedView);
      RD_MASK:    rdNext = DATA_W'(maskQ);
      RD_RAW:     rdNext = DATA_W'(rawQ);
      RD_ABORT:   rdNext = DATA_W'(abortQ);
      RD_CLR_ALL: rdNext = DATA_W'(rawQ);
      RD_CLR_ONE: rdNext = DATA_W'(rawQ[strb.rdIdx]);
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busRdata <= '0;
    else if (strb.rdEn) busRdata <= rdNext;
  end

  AST_EVENT_SETS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawQ & $past(srcEvent & ~LEVEL_SRC)) == $past(srcEvent & ~LEVEL_SRC))) else $error("event lost"); // R7
  AST_CLEAR_DROPS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawQ & $past(strb.clrVec & ~srcEvent)) == '0)) else $error("cleared bit still set"); // R5
  AST_UNCLEARED_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawQ & $past(rawQ & ~strb.clrVec & ~LEVEL_SRC)) == $past(rawQ & ~strb.clrVec & ~LEVEL_SRC))) else $error("sticky bit dropped"); // R2
  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawQ & LEVEL_SRC) == $past(srcEvent & LEVEL_SRC))) else $error("level bit mismatch"); // R3
  AST_ABORT_EMPTIED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrAbort && !srcEvent[B_TX_ABRT]) |=> (abortQ == '0)) else $error("abort reason kept"); // R8
  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(rawQ & maskQ)))) else $error("irq latency"); // R9
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irqstat_pkg::*;
#(
  parameter logic [SRC_N-1:0] MASK_RESET = 12'h254
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [SRC_N-1:0]   srcEvent,
  input  logic [ABORT_W-1:0] abortReason,
  output logic               irqOut
);
  ctlStrobe_t strb;

  irqstat_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb)
  );

  irqstat_datapath #(.MASK_RESET(MASK_RESET)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busWdata    (busWdata),
    .srcEvent    (srcEvent),
    .abortReason (abortReason),
    .busRdata    (busRdata),
    .irqOut      (irqOut)
  );
endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [11:0] srcEvent = '0;
  logic [12:0] abortReason = '0;
  logic        irqOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcEvent(srcEvent),
    .abortReason(abortReason), .irqOut(irqOut)
  );

  // {events, mask, expected masked status}
  localparam logic [35:0] VEC [6] = '{
    {12'h001, 12'hFFF, 12'h001},
    {12'h240, 12'h254, 12'h240},
    {12'h80A, 12'h254, 12'h000},
    {12'hFEB, 12'h0F0, 12'h0E0},
    {12'hA00, 12'h000, 12'h000},
    {12'h100, 12'h100, 12'h100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk); busSel = 1'b0; d = busRdata;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] e, input logic [12:0] r);
    @(negedge clk); srcEvent = e; abortReason = r;
    @(negedge clk); srcEvent = '0; abortReason = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    busRead(8'h04, d); check("R1 mask", d, 32'h254);
    busRead(8'h08, d); check("R1 raw", d, 32'h0);
    busRead(8'h0C, d); check("R1 abort", d, 32'h0);

    // R2 R4 R9 vector table
    foreach (VEC[i]) begin
      busRead(8'h10, d);
      busWrite(8'h04, {20'h0, VEC[i][23:12]});
      pulse(VEC[i][35:24], 13'h0);
      busRead(8'h00, d); check("R4 masked", d, {20'h0, VEC[i][11:0]});
      check("R9 irq", {31'b0, irqOut}, {31'b0, |VEC[i][11:0]});
      busRead(8'h08, d); check("R2 raw", d, {20'h0, VEC[i][35:24]});
    end

    // R6 global clear returns pre-clear raw and empties sticky bits
    busRead(8'h10, d); check("R6 clrall rdata", d, 32'h100);
    busRead(8'h08, d); check("R6 raw after", d, 32'h0);

    // R5 single clear
    pulse(12'h241, 13'h0);
    busRead(8'h44, d); check("R5 clr9 rdata", d, 32'h1);
    busRead(8'h08, d); check("R5 raw after clr9", d, 32'h041);
    busRead(8'h2C, d); check("R5 clr3 rdata", d, 32'h0);
    busRead(8'h08, d); check("R5 raw unchanged", d, 32'h041);

    // R3 level sources
    busRead(8'h10, d);
    @(negedge clk); srcEvent = 12'h004;
    busRead(8'h28, d); check("R3 clr2 rdata", d, 32'h1);
    busRead(8'h10, d);
    busRead(8'h08, d); check("R3 level held", d, 32'h004);
    @(negedge clk); srcEvent = 12'h010;
    busRead(8'h08, d); check("R3 level follows", d, 32'h010);
    @(negedge clk); srcEvent = '0;
    busRead(8'h08, d); check("R3 level drops", d, 32'h0);

    // R7 event wins against its own clear
    @(negedge clk); srcEvent = 12'h001; busSel = 1'b1; busWr = 1'b0; busAddr = 8'h20;
    @(negedge clk); srcEvent = '0; busSel = 1'b0;
    check("R7 clr rdata pre", busRdata, 32'h0);
    busRead(8'h08, d); check("R7 bit kept", d, 32'h001);

    // R8 abort reason capture and clear
    busRead(8'h10, d);
    pulse(12'h040, 13'h1001);
    pulse(12'h040, 13'h0008);
    busRead(8'h0C, d); check("R8 reason accum", d, 32'h1009);
    @(negedge clk); abortReason = 13'h0400;
    @(negedge clk); abortReason = '0;
    busRead(8'h0C, d); check("R8 reason w/o event ignored", d, 32'h1009);
    busRead(8'h38, d); check("R8 clr6 rdata", d, 32'h1);
    busRead(8'h0C, d); check("R8 reason cleared", d, 32'h0);
    busRead(8'h08, d); check("R8 bit6 cleared", d, 32'h0);
    pulse(12'h040, 13'h0800);
    busRead(8'h10, d);
    busRead(8'h0C, d); check("R8 global clears reason", d, 32'h0);
    pulse(12'h040, 13'h0001);
    @(negedge clk); srcEvent = 12'h040; abortReason = 13'h1000;
    busSel = 1'b1; busWr = 1'b0; busAddr = 8'h38;
    @(negedge clk); srcEvent = '0; abortReason = '0; busSel = 1'b0;
    busRead(8'h0C, d); check("R7 abort reason same cycle", d, 32'h1000);
    busRead(8'h08, d); check("R7 abort bit same cycle", d, 32'h040);

    // R9 irq latency
    busRead(8'h10, d);
    busWrite(8'h04, 32'h001);
    @(negedge clk); srcEvent = 12'h001;
    @(negedge clk); srcEvent = '0;
    check("R9 irq not yet", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R9 irq set", {31'b0, irqOut}, 32'h1);
    @(negedge clk); busSel = 1'b1; busWr = 1'b0; busAddr = 8'h20;
    @(negedge clk); busSel = 1'b0;
    check("R9 irq still set", {31'b0, irqOut}, 32'h1);
    @(negedge clk);
    check("R9 irq cleared", {31'b0, irqOut}, 32'h0);

    // R10 writes elsewhere ignored, mask width
    pulse(12'h300, 13'h0);
    busWrite(8'h08, 32'h0);
    busWrite(8'h10, 32'h0);
    busWrite(8'h44, 32'h0);
    busRead(8'h08, d); check("R10 raw after writes", d, 32'h300);
    busWrite(8'h04, 32'hFFFF_F000);
    busRead(8'h04, d); check("R10 R4 mask upper bits dropped", d, 32'h0);
    busRead(8'h80, d); check("R10 unmapped read", d, 32'h0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule